// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits beside a processor that does not drive its own bus command strobes. The processor reports each bus cycle's type on three status lines. The all-ones code means that no cycle is in progress. The block watches these lines on every rising clock edge. A cycle starts when the lines leave the all-ones code. The block latches the cycle type at that point, pulses an address latch strobe, and then drives one command strobe for as long as the status stays non-passive. The command strobe is one of memory read, memory write, I/O read, I/O write or interrupt acknowledge. Alongside the strobe it drives a data transceiver enable and a direction select.

The cycle ends when the status returns to the all-ones code. At that point every command output is released. All outputs come from registers, so the surrounding logic sees clean, edge-aligned signals.

Top module: `bus_cmd_gen`

## Requirements
- R1: While reset is asserted, every command strobe is high (inactive), and latch strobe, data enable and transmit direction are low.
- R2: When the status sampled at a clock edge is non-passive and the status sampled at the previous edge was passive (111), `addr_latch` is high for exactly the one clock that follows that edge.
- R3: On the next edge, if the status is still non-passive, the command strobe for the captured type goes low. The mapping is: 000 drives `inta_n`, 001 drives `iord_n`, 010 drives `iowr_n`, 100 and 101 drive `mrd_n`, and 110 drives `mwr_n`. The strobe stays low while the status stays non-passive.
- R4: A code fetch (100) and a memory read (101) produce the same output behaviour on `mrd_n`.
- R5: A halt cycle (011) pulses `addr_latch` but asserts no command strobe and no `data_en`.
- R6: `data_en` is high exactly in the clocks where some command strobe is low.
- R7: `dir_tx` goes high with `addr_latch` for write types (010, 110) and stays high until the cycle ends. It is low for read, fetch, acknowledge and halt cycles, and low while idle.
- R8: After the edge at which a passive status is sampled, all command strobes are high, and `data_en` and `dir_tx` are low.
- R9: A change from one non-passive code to another, without passing through passive, starts no new cycle. It gives no new latch pulse, and the originally captured command stays in force.
- R10: At most one command strobe is low at any time.
- R11: A non-passive status that lasts a single sample, with passive sampled on the next edge, gives a latch pulse and no command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| status | input | 3 | Cycle type reported by the processor; 111 means passive |
| addr_latch | output | 1 | One-clock address latch pulse at the start of a cycle |
| data_en | output | 1 | Data transceiver enable, active high |
| dir_tx | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| mrd_n | output | 1 | Memory read command, active low |
| mwr_n | output | 1 | Memory write command, active low |
| iord_n | output | 1 | I/O read command, active low |
| iowr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |

## Verification
The latch pulse and the direction select appear one clock after the edge that samples the first non-passive code. Command strobes and data enable appear one clock later. Everything is released one clock after passive is sampled. The bench drives the status on falling edges and advances its reference model at each rising edge. It then compares every output at the next falling edge, so each result is checked in the exact clock where it is due.

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] status,
  output logic       addr_latch,
  output logic       data_en,
  output logic       dir_tx,
  output logic       mrd_n,
  output logic       mwr_n,
  output logic       iord_n,
  output logic       iowr_n,
  output logic       inta_n
);

  localparam logic [2:0] ST_ACK   = 3'b000;
  localparam logic [2:0] ST_IORD  = 3'b001;
  localparam logic [2:0] ST_IOWR  = 3'b010;
  localparam logic [2:0] ST_FETCH = 3'b100;
  localparam logic [2:0] ST_MRD   = 3'b101;
  localparam logic [2:0] ST_MWR   = 3'b110;
  localparam logic [2:0] ST_IDLE  = 3'b111;

  logic [2:0] prev_st;
  logic [2:0] kind;
  logic       in_cycle;
  logic [4:0] strb_n;   // {inta, iord, iowr, mrd, mwr}
  logic [4:0] sel;

  wire passive = (status == ST_IDLE);
  wire start   = (prev_st == ST_IDLE) && !passive;
  wire go      = in_cycle && !passive;
  wire is_wr   = (status == ST_IOWR) || (status == ST_MWR);

  always_comb begin
    sel = 5'b00000;
    if (go) begin
      case (kind)
        ST_ACK:           sel = 5'b10000;
        ST_IORD:          sel = 5'b01000;
        ST_IOWR:          sel = 5'b00100;
        ST_FETCH, ST_MRD: sel = 5'b00010;
        ST_MWR:           sel = 5'b00001;
        default:          sel = 5'b00000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_st    <= ST_IDLE;
      kind       <= ST_IDLE;
      in_cycle   <= 1'b0;
      addr_latch <= 1'b0;
      data_en    <= 1'b0;
      dir_tx     <= 1'b0;
      strb_n     <= 5'b11111;
    end else begin
      prev_st    <= status;
      addr_latch <= start;
      if (start) begin
        in_cycle <= 1'b1;
        kind     <= status;
      end else if (passive) begin
        in_cycle <= 1'b0;
      end
      if (start)        dir_tx <= is_wr;
      else if (passive) dir_tx <= 1'b0;
      strb_n  <= ~sel;
      data_en <= |sel;
    end
  end

  assign inta_n = strb_n[4];
  assign iord_n = strb_n[3];
  assign iowr_n = strb_n[2];
  assign mrd_n  = strb_n[1];
  assign mwr_n  = strb_n[0];

  p_latch_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch |=> !addr_latch);

  p_cmd_follows_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&strb_n) |-> $past(addr_latch));

  p_den_with_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> !(&strb_n));

  p_wr_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mwr_n || !iowr_n) |-> dir_tx);

  p_rd_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mrd_n || !iord_n || !inta_n) |-> !dir_tx);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    passive |=> (&strb_n && !data_en && !dir_tx));

  p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~strb_n) <= 1);

endmodule

// File: tb/bus_cmd_gen_tb.sv
module bus_cmd_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] status = 3'b111;
  logic addr_latch, data_en, dir_tx, mrd_n, mwr_n, iord_n, iowr_n, inta_n;

  int checks = 0;
  int errors = 0;

  logic [2:0] m_prev = 3'b111;
  logic [2:0] m_typ  = 3'b111;
  logic       m_cyc  = 1'b0;
  logic       e_ale  = 1'b0;
  logic       e_den  = 1'b0;
  logic       e_dt   = 1'b0;
  logic [4:0] e_strb = 5'b11111;

  always #2 clk = ~clk;

  bus_cmd_gen dut_i (
    .clk(clk), .rst_n(rst_n), .status(status),
    .addr_latch(addr_latch), .data_en(data_en), .dir_tx(dir_tx),
    .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n), .iowr_n(iowr_n), .inta_n(inta_n)
  );

  // Active-low strobe vector {inta, iord, iowr, mrd, mwr} per the R3 mapping
  function automatic logic [4:0] strobe_for(input logic [2:0] t);
    case (t)
      3'b000:         return 5'b01111;
      3'b001:         return 5'b10111;
      3'b010:         return 5'b11011;
      3'b100, 3'b101: return 5'b11101;
      3'b110:         return 5'b11110;
      default:        return 5'b11111;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    logic [4:0] s;
    s = {inta_n, iord_n, iowr_n, mrd_n, mwr_n};
    check("R2", "addr_latch", {4'b0, addr_latch}, {4'b0, e_ale});
    check(tag, "strobes", s, e_strb);
    check("R6", "data_en", {4'b0, data_en}, {4'b0, e_den});
    check("R7", "dir_tx", {4'b0, dir_tx}, {4'b0, e_dt});
    check("R10", "strobe count", 5'($countones(~s) > 1), 5'b0);
  endtask

  task automatic step(input logic [2:0] s, input string tag);
    logic st, go;
    status = s;
    @(posedge clk);
    st = (m_prev == 3'b111) && (s != 3'b111);
    go = m_cyc && (s != 3'b111);
    e_ale  = st;
    e_strb = go ? strobe_for(m_typ) : 5'b11111;
    e_den  = go && (m_typ != 3'b011) && (m_typ != 3'b111);
    if (st) e_dt = (s == 3'b010) || (s == 3'b110);
    else if (s == 3'b111) e_dt = 1'b0;
    if (st) begin m_cyc = 1'b1; m_typ = s; end
    else if (s == 3'b111) m_cyc = 1'b0;
    m_prev = s;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog run did not complete actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0086));
    repeat (3) @(negedge clk);
    compare("R1");
    check("R1", "reset strobes", {inta_n, iord_n, iowr_n, mrd_n, mwr_n}, 5'b11111);
    rst_n = 1'b1;
    step(3'b111, "R1");

    // R3: each type, several clocks long
    for (int t = 0; t < 7; t++) begin
      step(3'(t), "R3"); step(3'(t), "R3"); step(3'(t), "R3");
      step(3'b111, "R8"); step(3'b111, "R8");
    end
    // R4: fetch vs memory read
    step(3'b100, "R4"); step(3'b100, "R4"); check("R4", "fetch mrd", {4'b0, mrd_n}, 5'b0);
    step(3'b111, "R8");
    step(3'b101, "R4"); step(3'b101, "R4"); check("R4", "read mrd", {4'b0, mrd_n}, 5'b0);
    step(3'b111, "R8");
    // R5: halt
    step(3'b011, "R5"); step(3'b011, "R5"); step(3'b011, "R5");
    check("R5", "halt quiet", {data_en, inta_n, iord_n, iowr_n, mrd_n}, 5'b01111);
    step(3'b111, "R8");
    // R9: code changes without passive
    step(3'b101, "R9"); step(3'b101, "R9"); step(3'b110, "R9"); step(3'b000, "R9");
    check("R9", "kept mrd", {mwr_n, inta_n, mrd_n, addr_latch, 1'b0}, 5'b11000);
    step(3'b111, "R8");
    // R11: single-sample cycle
    step(3'b001, "R11"); step(3'b111, "R11");
    check("R11", "no strobe", {inta_n, iord_n, iowr_n, mrd_n, mwr_n}, 5'b11111);
    step(3'b110, "R7"); step(3'b111, "R11"); step(3'b111, "R8");

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] r;
      r = ($urandom_range(0, 9) < 4) ? 3'b111 : 3'($urandom_range(0, 7));
      if (m_cyc && $urandom_range(0, 3) != 0) r = (r == 3'b111) ? 3'b111 : m_prev;
      step(r, "R3");
    end
    step(3'b111, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule